// File: doc/BRIEF.md
# Single-Line Bus Master Read-Slot Sequencer

This block acts as the bus master for one read time slot on a single open-drain data line. A start request in the idle state opens a slot. The block pulls the line low for a short read-low interval and then lets go. It samples the line once, late in the window in which the slave's answer is valid. It waits out the full slot length so that the slave can recover, and then reports the received bit together with a one-cycle done strobe. A slave that answers 0 keeps the line low past the sample point. A slave that answers 1 leaves the line alone, so the line rises as soon as the master releases it.

All times are counted in clock cycles. Two timing sets are fixed by parameters: standard speed and a faster overdrive speed. A speed input chooses between them, and the choice is latched when a slot starts. The line input passes through a synchronizer before the sequencer reads it, and the sample instant is defined at the raw input, so the synchronizer delay is already accounted for. The read result is not a stream with back-pressure. Each slot yields exactly one bit, announced by `done_o`. The bit stays on `bit_o` until the next done pulse, so a consumer can take it at any time before then.

Top module: `owrd_read_slot`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `drive_low_o`, `busy_o` and `done_o` are 0 and `bit_o` is 0.
- R2: With `speed_i`=0 at the start edge, `drive_low_o` goes high on the clock edge that accepts `start_i` and stays high for exactly STD_RL cycles.
- R3: With `speed_i`=1 at the start edge, the drive pulse lasts OD_RL cycles and the slot lasts OD_SLOT cycles, using the overdrive sample offset OD_SAMP.
- R4: The returned bit equals the level of `line_i` as captured at the clock edge that comes SAMP cycles after the start edge (SAMP being STD_SAMP or OD_SAMP). A line held low through that edge gives 0, and a line released before it gives 1.
- R5: `busy_o` is high for exactly SLOT cycles from the start edge. `done_o` is high for one cycle, namely the first cycle in which `busy_o` is low again.
- R6: A start request while `busy_o` is high is ignored. The slot keeps its drive length, its slot length and its result.
- R7: A change of `speed_i` during a slot has no effect on that slot's timing.
- R8: `bit_o` changes only in a cycle in which `done_o` is high, and it keeps its value between done pulses.
- R9: With `start_i` held high, the next slot starts on the edge right after the done edge, so `busy_o` is low for exactly one cycle between the two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one read slot; taken only when idle |
| speed_i | input | 1 | 0 = standard timing set, 1 = overdrive timing set |
| line_i | input | 1 | Raw level of the open-drain data line |
| drive_low_o | output | 1 | 1 = pull the data line low |
| busy_o | output | 1 | High from the start edge until the slot ends |
| done_o | output | 1 | One-cycle strobe: a new bit is on `bit_o` |
| bit_o | output | 1 | Received bit of the last completed slot |

## Verification
For each speed, the slave model holds the line low for every length from zero up to beyond the slot. This sweep separates a sample taken at the intended cycle from one taken a cycle early or late: the expected bit changes exactly when the hold length reaches the sample offset. Every slot also checks the drive length and the busy length, so a sequencer that restarts when start arrives mid-slot, or that follows a speed change mid-slot, shows up as a wrong count. A held start request exercises back-to-back slots and the single idle cycle between them.

// File: rtl/owrd_pkg.sv
package owrd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2
  } phase_e;

  typedef enum logic {
    SPD_STD = 1'b0,
    SPD_OD  = 1'b1
  } speed_e;
endpackage

// File: rtl/owrd_sync.sv
module owrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[i] <= 1'b1;
        else        q[i] <= q[i-1];
      end
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/owrd_tsel.sv
module owrd_tsel
  import owrd_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter int STD_RL      = 300,
  parameter int STD_SAMP    = 650,
  parameter int STD_SLOT    = 3250,
  parameter int OD_RL       = 50,
  parameter int OD_SAMP     = 90,
  parameter int OD_SLOT     = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             speed_i,
  output logic [CNT_W-1:0] rl_o,
  output logic [CNT_W-1:0] cap_o,
  output logic [CNT_W-1:0] slot_o
);
  localparam logic [CNT_W-1:0] S_RL   = CNT_W'(STD_RL);
  localparam logic [CNT_W-1:0] S_CAP  = CNT_W'(STD_SAMP + SYNC_STAGES);
  localparam logic [CNT_W-1:0] S_SLOT = CNT_W'(STD_SLOT);
  localparam logic [CNT_W-1:0] O_RL   = CNT_W'(OD_RL);
  localparam logic [CNT_W-1:0] O_CAP  = CNT_W'(OD_SAMP + SYNC_STAGES);
  localparam logic [CNT_W-1:0] O_SLOT = CNT_W'(OD_SLOT);

  speed_e spd;
  assign spd = speed_e'(speed_i);

  // Capture offset includes the synchronizer depth so that the sample
  // instant is defined at the raw line input.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rl_o   <= S_RL;
      cap_o  <= S_CAP;
      slot_o <= S_SLOT;
    end else if (load_i) begin
      rl_o   <= (spd == SPD_OD) ? O_RL   : S_RL;
      cap_o  <= (spd == SPD_OD) ? O_CAP  : S_CAP;
      slot_o <= (spd == SPD_OD) ? O_SLOT : S_SLOT;
    end
  end

  // R7: timing set frozen between slot starts
  a_r7_timing_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(rl_o) && $stable(cap_o) && $stable(slot_o)));
endmodule

// File: rtl/owrd_seq.sv
module owrd_seq
  import owrd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             line_s_i,
  input  logic [CNT_W-1:0] rl_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [CNT_W-1:0] slot_i,
  output logic             load_o,
  output logic             drive_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             bit_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic             smp;

  assign load_o = start_i && (ph == PH_IDLE);

  // cnt equals k at the k-th edge after the start edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      cnt         <= '0;
      drive_low_o <= 1'b0;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      bit_o       <= 1'b0;
      smp         <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start_i) begin
            ph          <= PH_LOW;
            cnt         <= CNT_ONE;
            drive_low_o <= 1'b1;
            busy_o      <= 1'b1;
          end
        end
        PH_LOW: begin
          cnt <= cnt + 1'b1;
          if (cnt == rl_i) begin
            drive_low_o <= 1'b0;
            ph          <= PH_REL;
          end
        end
        PH_REL: begin
          cnt <= cnt + 1'b1;
          if (cnt == cap_i) smp <= line_s_i;
          if (cnt == slot_i) begin
            ph     <= PH_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
            bit_o  <= (cnt == cap_i) ? line_s_i : smp;
            cnt    <= '0;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R2: the line is only driven inside a slot
  a_r2_drive_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low_o |-> busy_o);

  // R4: line released before the capture point
  a_r4_released_at_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_REL && cnt == cap_i) |-> !drive_low_o);

  // R5: done is a single-cycle strobe
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: done marks the first idle cycle after a slot
  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R6: a start during a slot does not restart the count
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt != slot_i) |=> (cnt == $past(cnt) + 1'b1));

  // R8: result changes only together with done
  a_r8_bit_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_o) |-> done_o);
endmodule

// File: rtl/owrd_read_slot.sv
module owrd_read_slot #(
  parameter int SYNC_STAGES = 2,
  parameter int STD_RL      = 300,
  parameter int STD_SAMP    = 650,
  parameter int STD_SLOT    = 3250,
  parameter int OD_RL       = 50,
  parameter int OD_SAMP     = 90,
  parameter int OD_SLOT     = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic speed_i,
  input  logic line_i,
  output logic drive_low_o,
  output logic busy_o,
  output logic done_o,
  output logic bit_o
);
  localparam int MAX_SLOT = (STD_SLOT > OD_SLOT) ? STD_SLOT : OD_SLOT;
  localparam int CNT_W    = $clog2(MAX_SLOT + 1) + 1;

  logic             line_s;
  logic             load;
  logic [CNT_W-1:0] rl, cap, slot;

  owrd_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (line_i),
    .dout (line_s)
  );

  owrd_tsel #(
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .STD_RL     (STD_RL),
    .STD_SAMP   (STD_SAMP),
    .STD_SLOT   (STD_SLOT),
    .OD_RL      (OD_RL),
    .OD_SAMP    (OD_SAMP),
    .OD_SLOT    (OD_SLOT)
  ) tsel_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .speed_i(speed_i),
    .rl_o   (rl),
    .cap_o  (cap),
    .slot_o (slot)
  );

  owrd_seq #(.CNT_W(CNT_W)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .line_s_i   (line_s),
    .rl_i       (rl),
    .cap_i      (cap),
    .slot_i     (slot),
    .load_o     (load),
    .drive_low_o(drive_low_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .bit_o      (bit_o)
  );
endmodule

// File: tb/owrd_read_slot_tb.sv
module owrd_read_slot_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int S_RL = 3, S_SAMP = 8, S_SLOT = 16;
  localparam int O_RL = 1, O_SAMP = 3, O_SLOT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic speed = 1'b0;
  logic slave_low = 1'b0;
  logic drive_low, busy, done, rbit;
  logic line;
  int   hold = 0;
  int   k = 0;
  int   nchk = 0;
  int   errors = 0;

  assign line = !(drive_low || slave_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  owrd_read_slot #(
    .SYNC_STAGES(2),
    .STD_RL(S_RL), .STD_SAMP(S_SAMP), .STD_SLOT(S_SLOT),
    .OD_RL(O_RL),  .OD_SAMP(O_SAMP),  .OD_SLOT(O_SLOT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .speed_i(speed),
    .line_i(line), .drive_low_o(drive_low), .busy_o(busy),
    .done_o(done), .bit_o(rbit)
  );

  // Slave: holds the line low for 'hold' cycles counted from the slot start.
  always @(negedge clk) begin
    if (busy !== 1'b1) k = 0;
    else k = k + 1;
    slave_low = (busy === 1'b1) && (k <= hold);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_slot(input int spd, input int h, input bit poke, input bit flip);
    int dcnt = 0, bcnt = 0, cyc = 0;
    int e_rl   = spd ? O_RL : S_RL;
    int e_slot = spd ? O_SLOT : S_SLOT;
    int e_bit  = (h < (spd ? O_SAMP : S_SAMP)) ? 1 : 0;
    logic b0;
    hold = h;
    speed = spd[0];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (done !== 1'b1 && cyc < 1000) begin
      if (drive_low === 1'b1) dcnt++;
      if (busy === 1'b1) bcnt++;
      start = (poke && cyc == 2);
      if (flip && cyc == 1) speed = ~spd[0];
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    if (spd == 0) check(dcnt == e_rl, "R2 drive length", dcnt, e_rl);
    else          check(dcnt == e_rl, "R3 drive length", dcnt, e_rl);
    if (poke)      check(bcnt == e_slot, "R6 busy length", bcnt, e_slot);
    else if (flip) check(bcnt == e_slot, "R7 busy length", bcnt, e_slot);
    else           check(bcnt == e_slot, "R5 busy length", bcnt, e_slot);
    check(rbit === e_bit[0], "R4 sampled bit", int'(rbit), e_bit);
    b0 = rbit;
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R5 done single pulse", int'(done), 0);
    repeat (2) @(negedge clk);
    check(rbit === b0, "R8 bit held", int'(rbit), int'(b0));
    speed = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(drive_low === 1'b0 && busy === 1'b0 && done === 1'b0 && rbit === 1'b0,
          "R1 reset outputs", int'({drive_low, busy, done, rbit}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drive_low === 1'b0 && busy === 1'b0 && done === 1'b0 && rbit === 1'b0,
          "R1 after reset", int'({drive_low, busy, done, rbit}), 0);

    // Sweep slave hold lengths for both speeds (R2, R3, R4, R5, R8)
    for (int h = 0; h <= S_SLOT + 1; h++) run_slot(0, h, 1'b0, 1'b0);
    for (int h = 0; h <= O_SLOT + 1; h++) run_slot(1, h, 1'b0, 1'b0);

    // R6: start pokes during a slot
    run_slot(0, S_SAMP, 1'b1, 1'b0);
    run_slot(1, 0, 1'b1, 1'b0);
    // R7: speed flipped mid-slot
    run_slot(0, S_SAMP - 1, 1'b0, 1'b1);
    run_slot(1, O_SAMP, 1'b0, 1'b1);

    // R9: back-to-back slots with start held
    hold = 0;
    speed = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk);
    while (done !== 1'b1) @(negedge clk);
    check(busy === 1'b0, "R9 idle gap start", int'(busy), 0);
    @(negedge clk);
    check(busy === 1'b1 && drive_low === 1'b1, "R9 second slot starts", int'({busy, drive_low}), 3);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    check(rbit === 1'b1, "R9 second slot bit", int'(rbit), 1);
    speed = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    nchk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, nchk);
    $finish;
  end
endmodule